// File: doc/BRIEF.md
# Watchdog and Interval Timer with Feed Handshake

This block counts time with a 12-bit prescaler that drives an 8-bit down counter. Each decrement of the counter takes a selectable power-of-two number of prescaler ticks. The tick source is either every clock cycle or a pulse from a separate slow oscillator. Software programs the block through a simple write port. That port reaches four addresses: a control register, a reload register and two feed addresses.

In watchdog mode the block pulses a reset request when the counter runs out. It also pulses the request when the two-write feed handshake is broken, or when a control write is not followed directly by a valid feed. In interval-timer mode the same underflow raises an interrupt pulse instead, and a broken handshake is dropped without effect.

A control write goes first into a shadow copy. The active control value changes only on the next valid feed. A valid feed also reloads the counter and restarts the prescaler.

Top module: `wdt_feed_timer`

## Requirements
- R1: After reset the control output reads 0xE0 (prescale select 7, run 0, watchdog mode 0, timeout flag 0), the counter reads 0xFF, and both rst_req and irq are low.
- R2: Control byte layout is bit 0 run, bit 1 timeout flag, bit 2 watchdog mode, bits 4:3 read as zero, and bits 7:5 prescale select. A write to address 0 leaves run, mode and prescale select unchanged until a valid feed, which then copies them in.
- R3: A valid feed is a write of 0xA5 to address 2 followed in the very next write by 0x5A to address 3. The counter output equals the address-1 reload value on the cycle after the feed.
- R4: When running with a per-cycle tick, the counter decrements once every 2^(5+PRE) ticks. Underflow happens on the (reload+1)*2^(5+PRE)-th tick after a feed.
- R5: In watchdog mode an underflow gives a one-cycle rst_req pulse. It also sets the timeout flag and reloads the counter from the reload register.
- R6: In timer mode an underflow gives a one-cycle irq pulse and no rst_req, and it sets the timeout flag. irq and rst_req are never high together.
- R7: In watchdog mode a broken feed asserts rst_req on the cycle after the offending write. Three cases count as broken: a write to address 2 of a value other than 0xA5, a write to address 3 not directly preceded by the 0xA5 write, and any other write directly after the 0xA5 write.
- R8: In watchdog mode a control write whose next write is not the start of a valid feed asserts rst_req.
- R9: In timer mode a broken sequence does not assert rst_req. A pending control write is then discarded, so a later feed leaves the control output unchanged.
- R10: A control write with bit 1 at 0 clears the timeout flag at once. A write with bit 1 at 1 leaves it unchanged.
- R11: With run at 0 the counter holds its value.
- R12: With clk_sel low and pwr_down high the counter holds its value. With clk_sel high, only cycles where osc_tick is high advance the prescaler, whatever the state of pwr_down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 2 | 0 control, 1 reload, 2 first feed, 3 second feed |
| wr_data | input | 8 | Write data |
| clk_sel | input | 1 | 0: tick every cycle, 1: tick on osc_tick |
| osc_tick | input | 1 | Slow oscillator tick pulse |
| pwr_down | input | 1 | Power-down; stops the per-cycle tick |
| rst_req | output | 1 | System reset request pulse |
| irq | output | 1 | Interval interrupt pulse |
| ctrl_q | output | 8 | Active control value |
| count_q | output | 8 | Down counter value |

## Verification
The bench measures the exact underflow cycle for several prescale selects and reload values. A prescaler that is off by one tap, or that is not cleared by a feed, would miss that cycle.

It tries each way of breaking the handshake: a wrong first key, a lone second key, an interrupted pair, and a control write followed by something other than a feed. A design that tracked only key values, and not the order of writes, would miss one of these resets.

A random write stream is checked against a model of the handshake. Further checks confirm three things. The shadowed control value is dropped after a broken sequence in timer mode. The timeout flag clears only on a zero write. Power-down freezes the counter only when the per-cycle tick is selected.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

   typedef enum logic [1:0] {
      WA_CTRL   = 2'd0,
      WA_RELOAD = 2'd1,
      WA_FEED1  = 2'd2,
      WA_FEED2  = 2'd3
   } wdt_addr_e;

   typedef struct packed {
      logic [2:0] pre;
      logic [1:0] rsvd;
      logic       wd_en;
      logic       tmo;
      logic       run;
   } wdt_ctrl_t;

   localparam wdt_ctrl_t CTRL_RESET = '{pre: 3'd7, rsvd: 2'd0, wd_en: 1'b0, tmo: 1'b0, run: 1'b0};

endpackage

// File: rtl/wdt_feed_seq.sv
module wdt_feed_seq
   import wdt_pkg::*;
#(
   parameter int         DATA_W     = 8,
   parameter logic [7:0] KEY_FIRST  = 8'hA5,
   parameter logic [7:0] KEY_SECOND = 8'h5A
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic              feed_ok,
   output logic              feed_bad,
   output logic              ctrl_accept,
   output logic              armed_q,
   output logic              pending_q
);

   logic key1_hit;
   logic key2_hit;
   logic armed_d;
   logic pending_d;

   assign key1_hit = (wr_data == DATA_W'(KEY_FIRST));
   assign key2_hit = (wr_data == DATA_W'(KEY_SECOND));

   always_comb begin
      feed_ok     = 1'b0;
      feed_bad    = 1'b0;
      ctrl_accept = 1'b0;
      if (wr_en) begin
         case (wdt_addr_e'(wr_addr))
            WA_FEED1: begin
               if (!key1_hit || armed_q) feed_bad = 1'b1;
            end
            WA_FEED2: begin
               if (armed_q && key2_hit) feed_ok = 1'b1;
               else                     feed_bad = 1'b1;
            end
            WA_CTRL: begin
               if (armed_q || pending_q) feed_bad = 1'b1;
               else                      ctrl_accept = 1'b1;
            end
            default: begin
               if (armed_q || pending_q) feed_bad = 1'b1;
            end
         endcase
      end
   end

   always_comb begin
      armed_d   = armed_q;
      pending_d = pending_q;
      if (feed_bad || feed_ok) begin
         armed_d   = 1'b0;
         pending_d = 1'b0;
      end else if (ctrl_accept) begin
         pending_d = 1'b1;
      end else if (wr_en && wdt_addr_e'(wr_addr) == WA_FEED1) begin
         armed_d = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q   <= 1'b0;
         pending_q <= 1'b0;
      end else begin
         armed_q   <= armed_d;
         pending_q <= pending_d;
      end
   end

endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
   parameter int PRESCALE_W = 12,
   parameter int SEL_W      = 3,
   parameter int TAP_BASE   = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             tick,
   input  logic [SEL_W-1:0] sel,
   output logic             step
);

   localparam int NUM_TAPS = 1 << SEL_W;

   logic [PRESCALE_W-1:0] pre_q;
   logic [PRESCALE_W-1:0] tap_mask [NUM_TAPS];
   logic                  at_term;

   for (genvar i = 0; i < NUM_TAPS; i++) begin : g_tap
      localparam int EXP = TAP_BASE + i;
      assign tap_mask[i] = PRESCALE_W'((64'd1 << EXP) - 64'd1);
   end

   assign at_term = ((pre_q & tap_mask[sel]) == tap_mask[sel]);
   assign step    = tick && at_term && !clear;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre_q <= '0;
      end else if (clear) begin
         pre_q <= '0;
      end else if (tick) begin
         if (at_term) pre_q <= '0;
         else         pre_q <= pre_q + PRESCALE_W'(1);
      end
   end

endmodule

// File: rtl/wdt_downcount.sv
module wdt_downcount #(
   parameter int COUNT_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic [COUNT_W-1:0] load_val,
   input  logic               step,
   output logic [COUNT_W-1:0] count_q,
   output logic               underflow
);

   assign underflow = step && !load && (count_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count_q <= '1;
      end else if (load || underflow) begin
         count_q <= load_val;
      end else if (step) begin
         count_q <= count_q - COUNT_W'(1);
      end
   end

endmodule

// File: rtl/wdt_feed_timer.sv
module wdt_feed_timer
   import wdt_pkg::*;
#(
   parameter int         PRESCALE_W      = 12,
   parameter int         SEL_W           = 3,
   parameter int         TAP_BASE        = 5,
   parameter int         COUNT_W         = 8,
   parameter int         DATA_W          = 8,
   parameter int         OSC_SYNC_STAGES = 0,
   parameter logic [7:0] KEY_FIRST       = 8'hA5,
   parameter logic [7:0] KEY_SECOND      = 8'h5A
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [1:0]         wr_addr,
   input  logic [DATA_W-1:0]  wr_data,
   input  logic               clk_sel,
   input  logic               osc_tick,
   input  logic               pwr_down,
   output logic               rst_req,
   output logic               irq,
   output logic [7:0]         ctrl_q,
   output logic [COUNT_W-1:0] count_q
);

   localparam int TOP_EXP = TAP_BASE + (1 << SEL_W) - 1;

   if (TOP_EXP > PRESCALE_W) begin : g_chk_taps
      $error("prescaler too narrow for the largest tap");
   end
   if (COUNT_W > DATA_W) begin : g_chk_count
      $error("counter wider than the write data");
   end
   if (DATA_W != 8) begin : g_chk_data
      $error("control layout needs 8-bit data");
   end
   if (SEL_W != 3) begin : g_chk_sel
      $error("control layout holds a 3-bit prescale select");
   end

   wdt_ctrl_t           act_q;
   logic [2:0]          sh_pre_q;
   logic                sh_wd_q;
   logic                sh_run_q;
   logic [COUNT_W-1:0]  reload_q;
   logic                feed_ok;
   logic                feed_bad;
   logic                ctrl_accept;
   logic                armed_q;
   logic                pending_q;
   logic                osc_en;
   logic                tick;
   logic                step;
   logic                underflow;
   logic                ctrl_wr;

   if (OSC_SYNC_STAGES == 0) begin : g_osc_direct
      assign osc_en = osc_tick;
   end else begin : g_osc_sync
      logic [OSC_SYNC_STAGES-1:0] sync_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sync_q <= '0;
         else        sync_q <= {sync_q[OSC_SYNC_STAGES-2:0], osc_tick};
      end
      assign osc_en = sync_q[OSC_SYNC_STAGES-1];
   end

   assign tick    = act_q.run && (clk_sel ? osc_en : !pwr_down);
   assign ctrl_wr = wr_en && (wdt_addr_e'(wr_addr) == WA_CTRL);

   wdt_feed_seq #(
      .DATA_W     (DATA_W),
      .KEY_FIRST  (KEY_FIRST),
      .KEY_SECOND (KEY_SECOND)
   ) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en       (wr_en),
      .wr_addr     (wr_addr),
      .wr_data     (wr_data),
      .feed_ok     (feed_ok),
      .feed_bad    (feed_bad),
      .ctrl_accept (ctrl_accept),
      .armed_q     (armed_q),
      .pending_q   (pending_q)
   );

   wdt_prescaler #(
      .PRESCALE_W (PRESCALE_W),
      .SEL_W      (SEL_W),
      .TAP_BASE   (TAP_BASE)
   ) u_pre (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (feed_ok),
      .tick  (tick),
      .sel   (act_q.pre),
      .step  (step)
   );

   wdt_downcount #(
      .COUNT_W (COUNT_W)
   ) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (feed_ok),
      .load_val  (reload_q),
      .step      (step),
      .count_q   (count_q),
      .underflow (underflow)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reload_q <= '1;
         sh_pre_q <= CTRL_RESET.pre;
         sh_wd_q  <= CTRL_RESET.wd_en;
         sh_run_q <= CTRL_RESET.run;
      end else begin
         if (wr_en && wdt_addr_e'(wr_addr) == WA_RELOAD) reload_q <= wr_data[COUNT_W-1:0];
         if (ctrl_accept) begin
            sh_pre_q <= wr_data[7:5];
            sh_wd_q  <= wr_data[2];
            sh_run_q <= wr_data[0];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q <= CTRL_RESET;
      end else begin
         if (feed_ok && pending_q) begin
            act_q.pre   <= sh_pre_q;
            act_q.wd_en <= sh_wd_q;
            act_q.run   <= sh_run_q;
         end
         if (underflow)                  act_q.tmo <= 1'b1;
         else if (ctrl_wr && !wr_data[1]) act_q.tmo <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rst_req <= 1'b0;
         irq     <= 1'b0;
      end else begin
         rst_req <= act_q.wd_en && (underflow || feed_bad);
         irq     <= !act_q.wd_en && underflow;
      end
   end

   assign ctrl_q = act_q;

endmodule

// File: rtl/wdt_feed_timer_chk.sv
module wdt_feed_timer_chk #(
   parameter int         COUNT_W   = 8,
   parameter logic [7:0] KEY_FIRST = 8'hA5
) (
   input logic               clk,
   input logic               rst_n,
   input logic               wr_en,
   input logic [1:0]         wr_addr,
   input logic [7:0]         wr_data,
   input logic               clk_sel,
   input logic               pwr_down,
   input logic               rst_req,
   input logic               irq,
   input logic [7:0]         ctrl_q,
   input logic [COUNT_W-1:0] count_q,
   input logic [COUNT_W-1:0] reload_q,
   input logic               feed_ok,
   input logic               feed_bad,
   input logic               armed_q,
   input logic               pending_q,
   input logic               underflow
);

   assert_ctrl_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !feed_ok |=> (ctrl_q & 8'hFD) == ($past(ctrl_q) & 8'hFD));

   assert_feed_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
      feed_ok |=> count_q == $past(reload_q));

   assert_underflow_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
      underflow |=> ctrl_q[1]);

   assert_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(rst_req && irq));

   assert_bad_feed_reset_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (feed_bad && ctrl_q[2]) |=> rst_req);

   assert_ctrl_unfed_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (pending_q && !armed_q && wr_en && ctrl_q[2] &&
       !(wr_addr == 2'd2 && wr_data == KEY_FIRST)) |=> rst_req);

   assert_timer_no_reset_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |-> $past(ctrl_q[2]));

   assert_stopped_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl_q[0] && !feed_ok) |=> count_q == $past(count_q));

   assert_powerdown_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (!clk_sel && pwr_down && !feed_ok) |=> count_q == $past(count_q));

endmodule

bind wdt_feed_timer wdt_feed_timer_chk #(
   .COUNT_W   (COUNT_W),
   .KEY_FIRST (KEY_FIRST)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .wr_en     (wr_en),
   .wr_addr   (wr_addr),
   .wr_data   (wr_data),
   .clk_sel   (clk_sel),
   .pwr_down  (pwr_down),
   .rst_req   (rst_req),
   .irq       (irq),
   .ctrl_q    (ctrl_q),
   .count_q   (count_q),
   .reload_q  (reload_q),
   .feed_ok   (feed_ok),
   .feed_bad  (feed_bad),
   .armed_q   (armed_q),
   .pending_q (pending_q),
   .underflow (underflow)
);

// File: tb/wdt_feed_timer_tb.sv
module wdt_feed_timer_tb;

   localparam logic [1:0] A_CTRL = 2'd0, A_RELOAD = 2'd1, A_F1 = 2'd2, A_F2 = 2'd3;
   localparam logic [7:0] K1 = 8'hA5, K2 = 8'h5A;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [1:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic       clk_sel = 1'b0;
   logic       osc_tick = 1'b0;
   logic       pwr_down = 1'b0;
   logic       osc_on = 1'b0;
   logic       rst_req, irq;
   logic [7:0] ctrl_q, count_q;

   int tests = 0;
   int fails = 0;
   bit done = 0;
   bit m_armed = 0;
   bit m_pend = 0;

   always #4 clk = ~clk;

   always @(negedge clk) osc_tick <= osc_on ? ~osc_tick : 1'b0;

   wdt_feed_timer u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .clk_sel(clk_sel), .osc_tick(osc_tick), .pwr_down(pwr_down),
      .rst_req(rst_req), .irq(irq), .ctrl_q(ctrl_q), .count_q(count_q)
   );

   function automatic int exp_cycles(input int rl, input int p);
      return (rl + 1) << (5 + p);
   endfunction

   task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic feed();
      wr(A_F1, K1);
      wr(A_F2, K2);
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   // counts cycles until the wanted pulse; flags the other pulse if seen
   task automatic measure(input bit want_rst, output int n, output bit other);
      n = 0; other = 0;
      while (n < 20000) begin
         @(negedge clk);
         n++;
         if (want_rst ? irq : rst_req) other = 1;
         if (want_rst ? rst_req : irq) break;
      end
   endtask

   // model of the feed handshake (R7, R8)
   task automatic wr_model(input logic [1:0] a, input logic [7:0] d);
      bit bad = 0;
      case (a)
         A_F1:     if (d == K1 && !m_armed) m_armed = 1; else bad = 1;
         A_F2:     if (m_armed && d == K2) begin m_armed = 0; m_pend = 0; end else bad = 1;
         A_CTRL:   if (m_armed || m_pend) bad = 1; else m_pend = 1;
         default:  if (m_armed || m_pend) bad = 1;
      endcase
      if (bad) begin m_armed = 0; m_pend = 0; end
      wr(a, d);
      check(rst_req == bad, "R7/R8", "random write rst_req", rst_req, bad);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: run did not finish, actual 0 expected 1");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      int n;
      bit other;
      int rl, p;
      void'($urandom(32'd7321));
      idle(3);
      rst_n = 1'b1;
      idle(2);

      // R1
      check(ctrl_q == 8'hE0, "R1", "ctrl after reset", ctrl_q, 8'hE0);
      check(count_q == 8'hFF, "R1", "count after reset", count_q, 8'hFF);
      check(!rst_req && !irq, "R1", "pulses after reset", {rst_req, irq}, 0);

      // R2, R3, R11
      wr(A_RELOAD, 8'd3);
      wr(A_CTRL, 8'h00);
      check(ctrl_q == 8'hE0, "R2", "ctrl before feed", ctrl_q, 8'hE0);
      feed();
      check(ctrl_q == 8'h00, "R2", "ctrl after feed", ctrl_q, 8'h00);
      check(count_q == 8'd3, "R3", "count after feed", count_q, 3);
      idle(200);
      check(count_q == 8'd3 && !irq, "R11", "stopped count", count_q, 3);

      // R4, R6: directed then random prescale and reload
      for (int i = 0; i < 7; i++) begin
         if (i < 3) begin p = i; rl = 2; end
         else begin p = $urandom_range(0, 2); rl = $urandom_range(0, 3); end
         wr(A_RELOAD, 8'(rl));
         wr(A_CTRL, 8'((p << 5) | 1));
         feed();
         measure(1'b0, n, other);
         check(n == exp_cycles(rl, p), "R4", "cycles to underflow", n, exp_cycles(rl, p));
         check(!other, "R6", "rst_req in timer mode", other, 0);
         check(ctrl_q[1] && count_q == 8'(rl), "R6", "flag and reload", {ctrl_q[1], count_q}, {1'b1, 8'(rl)});
      end

      // R10
      wr(A_CTRL, 8'h02);
      check(ctrl_q[1] == 1'b1, "R10", "flag kept on write of 1", ctrl_q[1], 1);
      feed();
      wr(A_CTRL, 8'h00);
      check(ctrl_q[1] == 1'b0, "R10", "flag cleared on write of 0", ctrl_q[1], 0);
      feed();

      // R9
      wr(A_CTRL, 8'hE1);
      wr(A_RELOAD, 8'h10);
      check(!rst_req, "R9", "no reset in timer mode", rst_req, 0);
      feed();
      check(ctrl_q == 8'h00, "R9", "discarded control", ctrl_q, 8'h00);

      // R12
      clk_sel = 1'b0; pwr_down = 1'b1;
      wr(A_RELOAD, 8'd5);
      wr(A_CTRL, 8'h01);
      feed();
      idle(200);
      check(count_q == 8'd5 && !irq, "R12", "frozen in power-down", count_q, 5);
      clk_sel = 1'b1; osc_on = 1'b1;
      idle(70);
      check(count_q == 8'd4, "R12", "counts oscillator ticks", count_q, 4);
      osc_on = 1'b0; clk_sel = 1'b0; pwr_down = 1'b0;

      // R5
      wr(A_RELOAD, 8'd1);
      wr(A_CTRL, 8'h05);
      feed();
      measure(1'b1, n, other);
      check(n == exp_cycles(1, 0), "R5", "cycles to reset", n, exp_cycles(1, 0));
      check(!other, "R5", "irq in watchdog mode", other, 0);
      check(ctrl_q[1] && count_q == 8'd1, "R5", "flag and reload", {ctrl_q[1], count_q}, 9'h101);
      idle(1);
      check(!rst_req, "R5", "single-cycle pulse", rst_req, 0);
      wr(A_RELOAD, 8'hFF);
      wr(A_CTRL, 8'hE5);
      feed();
      check(ctrl_q == 8'hE5 && !rst_req, "R2", "watchdog mode entered", ctrl_q, 8'hE5);

      // R7 directed
      wr(A_F1, 8'h33);
      check(rst_req, "R7", "wrong first key", rst_req, 1);
      wr(A_F2, K2);
      check(rst_req, "R7", "lone second key", rst_req, 1);
      wr(A_F1, K1);
      wr(A_RELOAD, 8'hFF);
      check(rst_req, "R7", "interrupted pair", rst_req, 1);
      feed();
      check(!rst_req, "R7", "valid feed no reset", rst_req, 0);

      // R8 directed
      wr(A_CTRL, 8'hE5);
      wr(A_RELOAD, 8'hFF);
      check(rst_req, "R8", "control then reload", rst_req, 1);
      wr(A_CTRL, 8'hE5);
      wr(A_F2, K2);
      check(rst_req, "R8", "control then second key", rst_req, 1);
      wr(A_CTRL, 8'hE5);
      feed();
      check(!rst_req, "R8", "control then feed", rst_req, 0);

      // random handshake stream
      m_armed = 0; m_pend = 0;
      for (int i = 0; i < 150; i++) begin
         case ($urandom_range(0, 5))
            0: begin wr_model(A_F1, K1); wr_model(A_F2, K2); end
            1: wr_model(A_F1, $urandom_range(0, 1) ? K1 : 8'($urandom_range(0, 255)));
            2: wr_model(A_F2, $urandom_range(0, 1) ? K2 : 8'($urandom_range(0, 255)));
            3: wr_model(A_RELOAD, 8'($urandom_range(240, 255)));
            4: wr_model(A_CTRL, 8'hE5);
            default: wr_model(A_F1, K1);
         endcase
         if ($urandom_range(0, 3) == 0) idle(1);
      end

      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule